// File: doc/BRIEF.md
# Program-ROM Outer-Bank Mapper

This block sits between a CPU write path and program-memory address generation in a cartridge controller. It watches CPU writes. Writes into the 0x5000–0x5FFF range load four outer configuration registers. Writes at 0x8000, 0x8001 and 0xA001 load a bank-select control byte, an inner bank register and a RAM control byte. From these it produces one program-memory bank number (in 8 KiB units) for each of the four 8 KiB windows at 0x8000, 0xA000, 0xC000 and 0xE000.

A 12-bit outer base is assembled from fields scattered across three outer registers. A 3-bit mode selects one of several layouts. The window can be a single 32 KiB bank, a 16 KiB bank mirrored into both halves, or four 8 KiB windows. In the 8 KiB layout the inner bank bits are masked to a width set by the mode, and the rest comes from the outer base. An extended setting instead uses four full inner registers, ORed onto the base.

A 3-bit static selector picks which address bit enables outer-register writes. The RAM control byte can lock the outer registers.

Top module: `prg_bank_mapper`

## Requirements
- R1: With reset high, all four window outputs are 0. On the first rising edge after reset is released, the windows for 0x8000, 0xA000, 0xC000 and 0xE000 read 0x000, 0x001, 0x03E and 0x03F.
- R2: The outer base is a 12-bit value built as follows:
  - bits 6:0 come from outer reg 1 bits 6:0;
  - bit 7 comes from outer reg 0 bit 3;
  - bit 8 comes from outer reg 0 bit 7;
  - bits 10:9 come from outer reg 2 bits 7:6;
  - bit 11 comes from outer reg 2 bit 5.
  The mode is outer reg 0 bits 2:0. In mode 4, and likewise in modes 5–7, window i outputs (base>>1)*4+i.
- R3: In mode 3, the 0x8000 and 0xC000 windows output base*2, and the 0xA000 and 0xE000 windows output base*2+1.
- R4: In modes 0–2 with outer reg 3 bit 1 clear, the mask is 0x3F>>mode and outer = (base*2) with the mask bits cleared. The four windows output, each ANDed with the mask and ORed with outer:
  - 0x8000: inner reg 6;
  - 0xA000: inner reg 7;
  - 0xC000: the constant 0xFE;
  - 0xE000: the constant 0xFF.
- R5: In modes 0–2 with outer reg 3 bit 1 set, the four windows output inner regs 6, 7, 8 and 9, each ORed with base*2.
- R6: In modes 0–2, control byte bit 6 set swaps the sources of the 0x8000 and 0xC000 windows.
- R7: A write to 0x8001 loads the inner register whose index is the control byte's low bits. Four index bits are used when outer reg 3 bit 1 is set, and three otherwise. An index outside 6–9 changes no window output.
- R8: A write in 0x5000–0x5FFF loads outer reg (address & 3) only if address bit (4 + dip_sel) is 1. Otherwise it changes nothing.
- R9: A write at 0xA001 sets the lock bit from data bit 5 and the override bit from data bit 6. While the lock bit is 1 and the override bit is 0, outer-register writes are ignored.
- R10: A register write presented on one rising edge is visible on win_bank after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| dip_sel | input | 3 | Static selector of the outer-write enable address bit |
| win_bank | output | 52 | Four 13-bit 8 KiB bank numbers; element i is window 0x8000+i*0x2000 |

## Verification
The assertions check several properties on every cycle:
- ignored outer writes and out-of-range inner indices leave their state unchanged;
- mode 3 mirrors its two 16 KiB halves;
- mode 4 outputs consecutive low bits;
- in the classic 8 KiB layout the top window carries all-ones inner bits.

Only the bench scenarios show the exact placement of each base field, the mask width per mode, the window swap, extended-register selection, the dip-selected enable bit and the one-cycle output latency.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int BASE_W  = 12;
  localparam int BANK_W  = BASE_W + 1;
  localparam int NWIN    = 4;
  localparam int INNER_N = 4;   // inner regs 6..9 feed program windows
endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_map_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [2:0]                     dip_sel,
  output logic [2:0]                     mode,
  output logic                           o0_b3,
  output logic                           o0_b7,
  output logic [6:0]                     o1_lo,
  output logic [2:0]                     o2_hi,
  output logic                           ext_en,
  output logic                           swap_en,
  output logic [INNER_N-1:0][DATA_W-1:0] inner
);
  logic [3:0] ctrl_idx;
  logic       lock_bit, ovr_bit;

  logic [7:0] dip_win;
  logic       lo_region, dip_hit, lo_open, outer_we;
  logic       hi_wr, ctrl_we, data_we, ram_we;
  logic [3:0] sel_idx;
  logic       slot_hit;
  logic [1:0] slot;
  logic       unused_bits;

  assign unused_bits = ^wr_addr[3:2];
  assign dip_win   = wr_addr[11:4];
  assign dip_hit   = dip_win[dip_sel];
  assign lo_region = (wr_addr[15:12] == 4'h5);
  assign lo_open   = !lock_bit || ovr_bit;
  assign outer_we  = wr_en && lo_region && dip_hit && lo_open;

  assign hi_wr   = wr_en && wr_addr[15];
  assign ctrl_we = hi_wr && ({wr_addr[14:13], wr_addr[0]} == 3'b000);
  assign data_we = hi_wr && ({wr_addr[14:13], wr_addr[0]} == 3'b001);
  assign ram_we  = hi_wr && ({wr_addr[14:13], wr_addr[0]} == 3'b011);

  assign sel_idx  = ctrl_idx & (ext_en ? 4'hF : 4'h7);
  assign slot_hit = (sel_idx >= 4'd6) && (sel_idx <= 4'd9);
  assign slot     = sel_idx[1:0] - 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= '0;
      o0_b3 <= 1'b0;
      o0_b7 <= 1'b0;
      o1_lo <= '0;
      o2_hi <= '0;
      ext_en <= 1'b0;
    end else if (outer_we) begin
      case (wr_addr[1:0])
        2'd0: begin
          mode  <= wr_data[2:0];
          o0_b3 <= wr_data[3];
          o0_b7 <= wr_data[7];
        end
        2'd1: o1_lo  <= wr_data[6:0];
        2'd2: o2_hi  <= wr_data[7:5];
        default: ext_en <= wr_data[1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_idx <= '0;
      swap_en  <= 1'b0;
      lock_bit <= 1'b0;
      ovr_bit  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_idx <= wr_data[3:0];
        swap_en  <= wr_data[6];
      end
      if (ram_we) begin
        lock_bit <= wr_data[5];
        ovr_bit  <= wr_data[6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inner[0] <= 8'h00;
      inner[1] <= 8'h01;
      inner[2] <= 8'hFE;
      inner[3] <= 8'hFF;
    end else if (data_we && slot_hit) begin
      inner[slot] <= wr_data;
    end
  end

  // R8 R9
  blocked_outer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lo_region && !(dip_hit && lo_open)) |=>
      $stable({mode, o0_b3, o0_b7, o1_lo, o2_hi, ext_en}));

  // R7
  inner_idx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (data_we && !slot_hit) |=> $stable(inner));
endmodule

// File: rtl/prg_base_build.sv
module prg_base_build
  import prg_map_pkg::*;
(
  input  logic              o0_b3,
  input  logic              o0_b7,
  input  logic [6:0]        o1_lo,
  input  logic [2:0]        o2_hi,
  output logic [BASE_W-1:0] base
);
  // o2_hi holds outer reg 2 bits 7:5
  assign base = {o2_hi[0], o2_hi[2:1], o0_b7, o0_b3, o1_lo};
endmodule

// File: rtl/prg_window_calc.sv
module prg_window_calc
  import prg_map_pkg::*;
(
  input  logic [2:0]                     mode,
  input  logic [BASE_W-1:0]              base,
  input  logic                           ext_en,
  input  logic                           swap_en,
  input  logic [INNER_N-1:0][DATA_W-1:0] inner,
  output logic [NWIN-1:0][BANK_W-1:0]    bank
);
  logic [BANK_W-1:0] base2, mask_w, outer_c;
  logic [5:0]        mask6;
  logic [NWIN-1:0][DATA_W-1:0] src;

  assign base2   = {base, 1'b0};
  assign mask6   = 6'h3F >> mode[1:0];
  assign mask_w  = {{(BANK_W-6){1'b0}}, mask6};
  assign outer_c = base2 & ~mask_w;

  assign src[0] = inner[0];
  assign src[1] = inner[1];
  assign src[2] = ext_en ? inner[2] : 8'hFE;
  assign src[3] = ext_en ? inner[3] : 8'hFF;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [DATA_W-1:0] pick;
    logic [BANK_W-1:0] pick_w;
    if (w == 0 || w == 2) begin : g_swp
      assign pick = swap_en ? src[w ^ 2] : src[w];
    end else begin : g_fix
      assign pick = src[w];
    end
    assign pick_w = {{(BANK_W-DATA_W){1'b0}}, pick};

    always_comb begin
      if (mode[2])
        bank[w] = {base[BASE_W-1:1], 2'(w)};
      else if (mode == 3'd3)
        bank[w] = {base, 1'(w)};
      else if (ext_en)
        bank[w] = pick_w | base2;
      else
        bank[w] = (pick_w & mask_w) | outer_c;
    end
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [2:0]                  dip_sel,
  output logic [NWIN-1:0][BANK_W-1:0] win_bank
);
  logic [2:0]                     mode;
  logic                           o0_b3, o0_b7, ext_en, swap_en;
  logic [6:0]                     o1_lo;
  logic [2:0]                     o2_hi;
  logic [INNER_N-1:0][DATA_W-1:0] inner;
  logic [BASE_W-1:0]              base;
  logic [NWIN-1:0][BANK_W-1:0]    bank_nx;

  prg_wr_decode u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dip_sel(dip_sel), .mode(mode),
    .o0_b3(o0_b3), .o0_b7(o0_b7), .o1_lo(o1_lo), .o2_hi(o2_hi),
    .ext_en(ext_en), .swap_en(swap_en), .inner(inner)
  );

  prg_base_build u_base (
    .o0_b3(o0_b3), .o0_b7(o0_b7), .o1_lo(o1_lo), .o2_hi(o2_hi),
    .base(base)
  );

  prg_window_calc u_win (
    .mode(mode), .base(base), .ext_en(ext_en), .swap_en(swap_en),
    .inner(inner), .bank(bank_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) win_bank <= '0;
    else     win_bank <= bank_nx;
  end

  // R3
  mirror16_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 3'd3 && !$past(rst)) |->
      (win_bank[0] == win_bank[2] && win_bank[1] == win_bank[3] &&
       win_bank[1] == win_bank[0] + 1'b1));

  // R2
  bank32_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode[2]) && !$past(rst)) |->
      (win_bank[0][1:0] == 2'd0 && win_bank[3] == win_bank[0] + 2'd3));

  // R4
  classic_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) < 3'd3 && !$past(ext_en)) |->
      ((win_bank[3][5:0] | ~(6'h3F >> $past(mode[1:0]))) == 6'h3F));
endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  dip_sel = 3'd0;
  logic [3:0][12:0] win_bank;

  int checks = 0;
  int fails  = 0;
  logic [51:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  prg_bank_mapper u_prg_bank_mapper (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dip_sel(dip_sel), .win_bank(win_bank)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect4(input logic [12:0] w0, input logic [12:0] w1,
                         input logic [12:0] w2, input logic [12:0] w3,
                         input string tag);
    @(negedge clk);
    exp_q.push_back({w3, w2, w1, w0});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      wait (exp_q.size() > 0);
      begin
        logic [51:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (win_bank !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, win_bank, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (win_bank !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=0", win_bank);
    end
    rst = 1'b0;
    expect4(13'h000, 13'h001, 13'h03E, 13'h03F, "R1 post-reset");
    // R2 base fields, 32 KiB mode
    wr(16'h5011, 8'h15);
    wr(16'h5012, 8'hE0);
    wr(16'h5010, 8'h0C);
    expect4(13'h1D28, 13'h1D29, 13'h1D2A, 13'h1D2B, "R2 mode4");
    // R3 16 KiB mirrored
    wr(16'h5010, 8'h0B);
    expect4(13'h1D2A, 13'h1D2B, 13'h1D2A, 13'h1D2B, "R3 mode3");
    // R10 latency: check immediately after capture edge, output still old
    wr(16'h5010, 8'h83);
    checks++;
    if (win_bank !== {13'h1D2B, 13'h1D2A, 13'h1D2B, 13'h1D2A}) begin
      fails++;
      $display("FAIL R10 latency actual=%h expected=old value", win_bank);
    end
    expect4(13'h1E2A, 13'h1E2B, 13'h1E2A, 13'h1E2B, "R2 R10 reg0 bit7");
    // R4 classic modes
    wr(16'h5012, 8'h00);
    wr(16'h5011, 8'h55);
    wr(16'h5010, 8'h00);
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'h2C);
    expect4(13'h0AC, 13'h081, 13'h0BE, 13'h0BF, "R4 mode0");
    wr(16'h5010, 8'h01);
    expect4(13'h0AC, 13'h0A1, 13'h0BE, 13'h0BF, "R4 mode1");
    wr(16'h5010, 8'h02);
    expect4(13'h0AC, 13'h0A1, 13'h0AE, 13'h0AF, "R4 mode2");
    // R6 swap
    wr(16'h8000, 8'h46);
    expect4(13'h0AE, 13'h0A1, 13'h0AC, 13'h0AF, "R6 swap");
    // R5 extended registers
    wr(16'h5013, 8'h02);
    wr(16'h8000, 8'h48);
    wr(16'h8001, 8'h33);
    wr(16'h8000, 8'h49);
    wr(16'h8001, 8'h44);
    expect4(13'h0BB, 13'h0AB, 13'h0AE, 13'h0EE, "R5 extended");
    // R7 index 12 ignored
    wr(16'h8000, 8'h4C);
    wr(16'h8001, 8'h77);
    expect4(13'h0BB, 13'h0AB, 13'h0AE, 13'h0EE, "R7 index12 ignored");
    // R7 three-bit index outside extended mode: 0x0E -> reg 6
    wr(16'h5013, 8'h00);
    wr(16'h8000, 8'h4E);
    wr(16'h8001, 8'h11);
    expect4(13'h0AE, 13'h0A1, 13'h0A1, 13'h0AF, "R7 idx masked to 3 bits");
    // R8 dip selects address bit 6
    dip_sel = 3'd2;
    wr(16'h5011, 8'h00);
    expect4(13'h0AE, 13'h0A1, 13'h0A1, 13'h0AF, "R8 bit4 ignored");
    wr(16'h5041, 8'h15);
    expect4(13'h02E, 13'h021, 13'h021, 13'h02F, "R8 bit6 accepted");
    // R9 lock
    wr(16'hA001, 8'h20);
    wr(16'h5041, 8'h55);
    expect4(13'h02E, 13'h021, 13'h021, 13'h02F, "R9 locked");
    wr(16'hA001, 8'h60);
    wr(16'h5041, 8'h55);
    expect4(13'h0AE, 13'h0A1, 13'h0A1, 13'h0AF, "R9 override");
    // R2 mode 7 behaves as 32 KiB
    wr(16'h5040, 8'h07);
    expect4(13'h0A8, 13'h0A9, 13'h0AA, 13'h0AB, "R2 mode7");
    wait (exp_q.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule